// File: doc/BRIEF.md
# Memory Ordering Window with Barrier Entries

This block holds the memory operations that a core has dispatched but not yet finished, and decides every cycle which of them may start executing under a relaxed ordering model. Each allocation names one of five operation kinds: load, store, load barrier, store barrier or full barrier. A side-effecting operation that may read is entered as a load barrier, one that may write as a store barrier, and one that may do both as a full barrier. Every operation, barriers included, takes one slot in a shared pool. A load counts against the load-side limit and a store against the store-side limit. A load barrier counts on the load side, a store barrier on the store side, and a full barrier on both.

The requester receives the index of the slot it was given and later retires that slot with a completion pulse. This frees the entry. Relative age is kept as an age matrix, and a combinational gate turns each held slot's kind and its set of older entries into an execute-permission bit. Loads may pass older loads. A store waits for everything older. Loads pass older stores only while the no-alias input is high. A barrier is granted only when it has become the oldest entry of the side or sides it belongs to.

Each slot is a two-state machine with the states SLOT_IDLE and SLOT_HELD. The transition "claim" (SLOT_IDLE to SLOT_HELD) fires when an allocation is accepted into that slot. The transition "release" (SLOT_HELD to SLOT_IDLE) fires when a completion names the slot.

Top module: `lsq_order_top`

## Requirements
- R1: The kind codes are 0 load, 1 store, 2 load barrier, 3 store barrier and 4 full barrier. `alloc_slot` always shows the lowest-numbered idle slot. A request is accepted (`alloc_accept` high) only when its code is 0 to 4, an idle slot exists and none of the side flags it counts against is set. Codes 5 to 7 are refused. An accepted request holds that slot from the next cycle on.
- R2: `ld_full` is high when every slot is held, or when `LQ_DEPTH` is nonzero and the held load-side entries (codes 0, 2 and 4) number at least `LQ_DEPTH`. While it is high, requests with codes 0, 2 and 4 are refused.
- R3: `st_full` is high when every slot is held, or when `SQ_DEPTH` is nonzero and the held store-side entries (codes 1, 3 and 4) number at least `SQ_DEPTH`. While it is high, requests with codes 1, 3 and 4 are refused.
- R4: A depth parameter of zero removes that side's own limit. Its flag then rises only when all slots are held.
- R5: A completion pulse on a held slot frees it from the next cycle on, and a younger slot no longer treats it as older. A completion aimed at an idle slot changes nothing.
- R6: A held load is granted whenever no older load barrier or full barrier is held. Older loads never hold it back.
- R7: While `no_alias` is low, a held load is also blocked by any older held store. While `no_alias` is high, older stores do not block it.
- R8: A held store is granted only when no older entry of any kind is held.
- R9: A load barrier is granted only when no older load, load barrier or full barrier is held. It blocks every younger load until it is freed.
- R10: A store barrier is granted only when no older store, store barrier or full barrier is held. It does not block younger loads.
- R11: A full barrier is granted only when no older entry of any kind is held. It blocks every younger entry until it is freed.
- R12: `exec_ok` bit i follows the current slot contents and `no_alias` in the same cycle, and it is never high for an idle slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| no_alias | input | 1 | When high, loads may pass older stores |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 3 | Operation kind code of the request |
| alloc_slot | output | $clog2(N_SLOTS) | Slot the request would be given |
| alloc_accept | output | 1 | Request taken this cycle |
| cmp_valid | input | 1 | Completion pulse |
| cmp_slot | input | $clog2(N_SLOTS) | Slot being completed |
| exec_ok | output | N_SLOTS | Per-slot execute permission |
| ld_full | output | 1 | Load side cannot accept |
| st_full | output | 1 | Store side cannot accept |

## Verification
The in-line properties watch a few things on every cycle. A granted slot is always held, and a granted store or full barrier never has a held older entry. A slot is claimed only from SLOT_IDLE, no slot ever lists itself as older, an accepted request really holds its slot one cycle later, and the load-side count never exceeds its limit. Other rules can only be shown by the bench, which compares every output each cycle against a sequence-numbered model. These are whether a load correctly bypasses or waits under each `no_alias` setting, the barrier blocking windows, the choice of the lowest idle slot, refusal when full, and the unbounded store side.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LBAR  = 3'd2,
        OP_SBAR  = 3'd3,
        OP_FBAR  = 3'd4
    } op_kind_e;

    typedef enum logic {
        SLOT_IDLE,
        SLOT_HELD
    } slot_state_e;

    function automatic logic kind_legal(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic on_load_side(input logic [2:0] k);
        return (k == OP_LOAD) || (k == OP_LBAR) || (k == OP_FBAR);
    endfunction

    function automatic logic on_store_side(input logic [2:0] k);
        return (k == OP_STORE) || (k == OP_SBAR) || (k == OP_FBAR);
    endfunction

endpackage

// File: rtl/lsq_slot.sv
module lsq_slot
    import lsq_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IDX     = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               claim,
    input  logic [2:0]         kind_in,
    input  logic               release_me,
    input  logic [N_SLOTS-1:0] held_vec,
    input  logic [N_SLOTS-1:0] rel_vec,
    output logic               held,
    output logic [2:0]         kind,
    output logic [N_SLOTS-1:0] older
);

    slot_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_IDLE: if (claim)      state_nx = SLOT_HELD;
            SLOT_HELD: if (release_me) state_nx = SLOT_IDLE;
            default:                   state_nx = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind  <= 3'd0;
            older <= '0;
        end else if (claim) begin
            kind  <= kind_in;
            older <= held_vec & ~rel_vec;
        end else begin
            older <= older & ~rel_vec;
        end
    end

    always_comb held = (state == SLOT_HELD);

    // R1: a slot is only ever claimed from the idle state
    assert_claim_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> state == SLOT_IDLE);

    // R5: the age row never marks the slot as older than itself
    assert_no_self_age_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !older[IDX]);

endmodule

// File: rtl/lsq_alloc.sv
module lsq_alloc
    import lsq_pkg::*;
#(
    parameter int N_SLOTS  = 8,
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 4,
    localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int CW = $clog2(N_SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SLOTS-1:0]      held_vec,
    input  logic [N_SLOTS-1:0][2:0] kinds,
    input  logic                    alloc_valid,
    input  logic [2:0]              alloc_kind,
    output logic [IW-1:0]           alloc_slot,
    output logic                    alloc_accept,
    output logic [N_SLOTS-1:0]      claim_vec,
    output logic                    ld_full,
    output logic                    st_full
);

    localparam bit LQ_LIMITED = (LQ_DEPTH != 0);
    localparam bit SQ_LIMITED = (SQ_DEPTH != 0);

    logic [CW-1:0] ld_n, st_n;
    logic          free_found;
    logic          all_held;

    always_comb begin
        ld_n       = '0;
        st_n       = '0;
        free_found = 1'b0;
        alloc_slot = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (held_vec[i]) begin
                if (on_load_side(kinds[i]))  ld_n = ld_n + CW'(1);
                if (on_store_side(kinds[i])) st_n = st_n + CW'(1);
            end else if (!free_found) begin
                free_found = 1'b1;
                alloc_slot = IW'(i);
            end
        end
    end

    always_comb begin
        all_held = &held_vec;
        ld_full  = all_held || (LQ_LIMITED && (32'(ld_n) >= LQ_DEPTH));
        st_full  = all_held || (SQ_LIMITED && (32'(st_n) >= SQ_DEPTH));
        alloc_accept = alloc_valid && kind_legal(alloc_kind) && free_found
                    && !(on_load_side(alloc_kind)  && ld_full)
                    && !(on_store_side(alloc_kind) && st_full);
        claim_vec = alloc_accept ? (N_SLOTS'(1) << alloc_slot) : '0;
    end

    // R2: the load side never holds more entries than its limit
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        LQ_LIMITED |-> 32'(ld_n) <= LQ_DEPTH);

    // R3: the store side never holds more entries than its limit
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        SQ_LIMITED |-> 32'(st_n) <= SQ_DEPTH);

endmodule

// File: rtl/lsq_gate.sv
module lsq_gate
    import lsq_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  logic                           no_alias,
    input  logic [N_SLOTS-1:0]             held_vec,
    input  logic [N_SLOTS-1:0][2:0]        kinds,
    input  logic [N_SLOTS-1:0][N_SLOTS-1:0] older,
    output logic [N_SLOTS-1:0]             exec_ok
);

    logic [N_SLOTS-1:0] is_ld, is_st, is_lb, is_sb, is_fb;

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            is_ld[i] = held_vec[i] && (kinds[i] == OP_LOAD);
            is_st[i] = held_vec[i] && (kinds[i] == OP_STORE);
            is_lb[i] = held_vec[i] && (kinds[i] == OP_LBAR);
            is_sb[i] = held_vec[i] && (kinds[i] == OP_SBAR);
            is_fb[i] = held_vec[i] && (kinds[i] == OP_FBAR);
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [N_SLOTS-1:0] live;
        logic o_ld, o_st, o_lb, o_sb, o_fb, o_any, ok;

        always_comb begin
            live  = older[g] & held_vec;
            o_ld  = |(live & is_ld);
            o_st  = |(live & is_st);
            o_lb  = |(live & is_lb);
            o_sb  = |(live & is_sb);
            o_fb  = |(live & is_fb);
            o_any = |live;
            unique case (kinds[g])
                OP_LOAD:  ok = !o_lb && !o_fb && (no_alias || !o_st);
                OP_STORE: ok = !o_any;
                OP_LBAR:  ok = !(o_ld || o_lb || o_fb);
                OP_SBAR:  ok = !(o_st || o_sb || o_fb);
                OP_FBAR:  ok = !o_any;
                default:  ok = 1'b0;
            endcase
            exec_ok[g] = held_vec[g] && ok;
        end
    end

endmodule

// File: rtl/lsq_order_top.sv
module lsq_order_top
    import lsq_pkg::*;
#(
    parameter int N_SLOTS  = 8,
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 4,
    localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               no_alias,
    input  logic               alloc_valid,
    input  logic [2:0]         alloc_kind,
    output logic [IW-1:0]      alloc_slot,
    output logic               alloc_accept,
    input  logic               cmp_valid,
    input  logic [IW-1:0]      cmp_slot,
    output logic [N_SLOTS-1:0] exec_ok,
    output logic               ld_full,
    output logic               st_full
);

    logic [N_SLOTS-1:0]              held_vec, claim_vec, rel_vec;
    logic [N_SLOTS-1:0][2:0]         kinds;
    logic [N_SLOTS-1:0][N_SLOTS-1:0] older;

    always_comb rel_vec = cmp_valid ? ((N_SLOTS'(1) << cmp_slot) & held_vec) : '0;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slots
        lsq_slot #(.N_SLOTS(N_SLOTS), .IDX(g)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .claim      (claim_vec[g]),
            .kind_in    (alloc_kind),
            .release_me (rel_vec[g]),
            .held_vec   (held_vec),
            .rel_vec    (rel_vec),
            .held       (held_vec[g]),
            .kind       (kinds[g]),
            .older      (older[g])
        );
    end

    lsq_alloc #(.N_SLOTS(N_SLOTS), .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)) u_alloc (
        .clk          (clk),
        .rst_n        (rst_n),
        .held_vec     (held_vec),
        .kinds        (kinds),
        .alloc_valid  (alloc_valid),
        .alloc_kind   (alloc_kind),
        .alloc_slot   (alloc_slot),
        .alloc_accept (alloc_accept),
        .claim_vec    (claim_vec),
        .ld_full      (ld_full),
        .st_full      (st_full)
    );

    lsq_gate #(.N_SLOTS(N_SLOTS)) u_gate (
        .no_alias (no_alias),
        .held_vec (held_vec),
        .kinds    (kinds),
        .older    (older),
        .exec_ok  (exec_ok)
    );

    // R1: an accepted request holds its slot on the following cycle
    assert_claim_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_accept |=> held_vec[$past(alloc_slot)]);

    // R12: permission never shows for a slot that is idle
    assert_exec_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ok & ~held_vec) == '0);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_chk
        // R8 / R11: a granted store or full barrier has no held older entry
        assert_oldest_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_ok[g] && (kinds[g] == OP_STORE || kinds[g] == OP_FBAR))
                |-> (older[g] & held_vec) == '0);
    end

endmodule

// File: tb/lsq_order_top_tb.sv
module lsq_order_top_tb;

    localparam int N  = 8;
    localparam int LQ = 4;
    localparam int SQ = 0;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          no_alias = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [2:0]    alloc_kind = 3'd0;
    logic [IW-1:0] alloc_slot;
    logic          alloc_accept;
    logic          cmp_valid = 1'b0;
    logic [IW-1:0] cmp_slot = '0;
    logic [N-1:0]  exec_ok;
    logic          ld_full, st_full;

    always #10 clk = ~clk;

    lsq_order_top #(.N_SLOTS(N), .LQ_DEPTH(LQ), .SQ_DEPTH(SQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .no_alias(no_alias),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
        .alloc_slot(alloc_slot), .alloc_accept(alloc_accept),
        .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
        .exec_ok(exec_ok), .ld_full(ld_full), .st_full(st_full)
    );

    bit m_held[N];
    int m_kind[N];
    int m_age[N];
    int seq = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    function automatic bit lside(int k); return k == 0 || k == 2 || k == 4; endfunction
    function automatic bit sside(int k); return k == 1 || k == 3 || k == 4; endfunction

    function automatic bit exp_ok(int i, bit na);
        bit o_ld = 0, o_st = 0, o_lb = 0, o_sb = 0, o_fb = 0;
        if (!m_held[i]) return 0;
        for (int j = 0; j < N; j++) begin
            if (m_held[j] && m_age[j] < m_age[i]) begin
                if (m_kind[j] == 0) o_ld = 1;
                if (m_kind[j] == 1) o_st = 1;
                if (m_kind[j] == 2) o_lb = 1;
                if (m_kind[j] == 3) o_sb = 1;
                if (m_kind[j] == 4) o_fb = 1;
            end
        end
        case (m_kind[i])
            0: return !o_lb && !o_fb && (na || !o_st);        // R6 R7 R9 R10 R11
            1: return !(o_ld || o_st || o_lb || o_sb || o_fb); // R8
            2: return !(o_ld || o_lb || o_fb);                 // R9
            3: return !(o_st || o_sb || o_fb);                 // R10
            default: return !(o_ld || o_st || o_lb || o_sb || o_fb); // R11
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // one cycle: drive, compare all outputs to the model, then advance the model
    task automatic step(bit av, int k, bit cv, int cs, bit na);
        int ldn = 0, stn = 0, slot = -1;
        bit allh = 1, lf, sf, acc;
        logic [N-1:0] ev;
        @(negedge clk);
        alloc_valid = av; alloc_kind = 3'(k); cmp_valid = cv; cmp_slot = IW'(cs); no_alias = na;
        #1;
        for (int i = 0; i < N; i++) begin
            if (m_held[i]) begin
                if (lside(m_kind[i])) ldn++;
                if (sside(m_kind[i])) stn++;
            end else begin
                allh = 0;
                if (slot < 0) slot = i;
            end
        end
        lf  = allh || (LQ != 0 && ldn >= LQ);
        sf  = allh || (SQ != 0 && stn >= SQ);
        acc = av && k <= 4 && slot >= 0 && !(lside(k) && lf) && !(sside(k) && sf);
        check(ld_full == lf, "R2 ld_full", int'(ld_full), int'(lf));
        check(st_full == sf, "R3 R4 st_full", int'(st_full), int'(sf));
        check(alloc_accept == acc, "R1 alloc_accept", int'(alloc_accept), int'(acc));
        if (slot >= 0) check(int'(alloc_slot) == slot, "R1 alloc_slot", int'(alloc_slot), slot);
        for (int i = 0; i < N; i++) ev[i] = exp_ok(i, na);
        check(exec_ok == ev, "R6 R7 R8 R9 R10 R11 R12 exec_ok", int'(exec_ok), int'(ev));
        @(posedge clk);
        if (cv && m_held[cs]) m_held[cs] = 0;          // R5
        if (acc) begin
            m_held[slot] = 1; m_kind[slot] = k; m_age[slot] = seq; seq++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_held[i] = 0; m_kind[i] = 0; m_age[i] = 0; end
        #1;
        // reset state
        check(exec_ok == '0, "R12 reset exec_ok", int'(exec_ok), 0);
        check(!ld_full && !st_full, "R2 R3 reset full", int'({ld_full, st_full}), 0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);

        // R7: load behind a store waits with no_alias low, goes with it high
        step(1, 0, 0, 0, 0);   // load  -> slot0
        step(1, 1, 0, 0, 0);   // store -> slot1
        step(1, 0, 0, 0, 0);   // load  -> slot2 (blocked)
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);   // R7 load2 released by no_alias
        // R1 undefined kind refused
        step(1, 6, 0, 0, 0);
        // R5 completion of idle slot ignored, then load0 completes, store now oldest (R8)
        step(0, 0, 1, 7, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        // R9 load barrier then a load: load waits
        step(1, 2, 0, 0, 1);   // lbar -> slot0
        step(1, 0, 0, 0, 1);   // load -> slot3
        // R2 load side fills at four
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);   // refused, load side full
        // R10 store barrier does not stop younger loads
        step(1, 3, 0, 0, 1);
        // drain in order
        for (int s = 0; s < N; s++) step(0, 0, 1, s, 1);
        // R11 full barrier ahead of everything
        step(1, 4, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        step(1, 1, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        // R4 store side unlimited: fill with stores until all slots held
        for (int s = 0; s < N; s++) step(1, 1, 0, 0, 0);
        for (int s = 0; s < N; s++) step(0, 0, 1, s, 0);

        // constrained random
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            int k  = ($urandom % 16 == 0) ? 5 + ($urandom % 3) : ($urandom % 5);
            bit av = ($urandom % 3) != 0;
            int cs = $urandom % N;
            bit na = ($urandom % 8) != 0;
            bit cv = ($urandom % 4) != 0 && (!m_held[cs] || exp_ok(cs, na));
            step(av, k, cv, cs, na);
        end
        finish_run();
    end

endmodule